// File: doc/BRIEF.md
# Dual-Channel Phase Accumulator for Quadrature Mixing

This block holds two independent numerically controlled oscillators. Each one produces the running phase that drives the cosine and sine lookups of a quadrature mixer. Each channel keeps a 24-bit phase step, and on every cycle with the sample enable raised it adds that step to a 24-bit accumulator. The addition wraps modulo 2^24. The accumulator word is exposed, together with its two top bits as a quadrant code, to a lookup stage outside this block. The lookup tables and the multipliers are not part of this block.

Software sets the oscillator frequency by writing the step in two 12-bit halves. A write with the half select low stores the low half in a per-channel holding register and leaves the running step alone. A write with the half select high joins the written upper half with the held lower half and makes the full step active, so the accumulator never sees a half-updated step. For an intermediate frequency f and a sample rate fs, the step is the truncated integer of (f / fs) * 2^24. At 10.7 MHz with fs = 18.432 MHz this gives 0x949C71: the upper half is 0x949 and the lower half is 0xC71.

Top module: `dual_nco_phase`

## Requirements
- R1: After reset both phase outputs, both quadrant outputs and both active steps are zero. Sample enables given before any write leave the phase at zero.
- R2: A write with `wr_hi`=0 only stores `wr_data` as the pending lower half of the channel chosen by `wr_chan`. Neither channel's accumulation changes.
- R3: A write with `wr_hi`=1 sets the chosen channel's step to {`wr_data`, pending lower half}. Accumulation uses the new step from the next clock edge on. A sample enable at the same edge as the write still adds the old step.
- R4: `wr_chan`=0 addresses channel A and `wr_chan`=1 addresses channel B. A write to one channel never alters the other channel's step or phase.
- R5: On each clock edge with `smp_en`=1, each phase becomes (phase + step) mod 2^24.
- R6: On each clock edge with `smp_en`=0, both phases hold their value.
- R7: Each quadrant output equals bits 23:22 of its channel's phase.
- R8: An upper-half write that follows no new lower-half write reuses the lower half held from the earlier write.
- R9: For f = 10.7 MHz and fs = 18.432 MHz, the step is truncated and not rounded: 0x949C71. The accumulator follows it exactly over many samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 1 | Channel select: 0 = A, 1 = B |
| wr_hi | input | 1 | Half select: 0 = lower half, 1 = upper half and commit |
| wr_data | input | 12 | Half-word of the phase step |
| smp_en | input | 1 | Sample enable; advances both accumulators |
| phase_a | output | 24 | Channel A phase word |
| phase_b | output | 24 | Channel B phase word |
| quad_a | output | 2 | Channel A quadrant (phase bits 23:22) |
| quad_b | output | 2 | Channel B quadrant (phase bits 23:22) |

## Verification
The bench raises the sample enable after a lone lower-half write. A design that applied halves at once would then drift to a mixed step. It also lands an upper-half write on the same edge as a sample enable, which catches a design that adds the new step one edge too early. A step of 0xFFFFFF exposes an accumulator that saturates or carries past 24 bits, and a quarter-turn step walks the quadrant code through all four values. The 10.7 MHz word is checked against the truncated formula, so a rounded step (0x949C72) would show up as phase error that grows with each sample.

// File: rtl/dual_nco_phase.sv
module dual_nco_phase #(
  parameter int HALF_W = 12,
  parameter int QUAD_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_chan,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wr_data,
  input  logic                  smp_en,
  output logic [2*HALF_W-1:0]   phase_a,
  output logic [2*HALF_W-1:0]   phase_b,
  output logic [QUAD_W-1:0]     quad_a,
  output logic [QUAD_W-1:0]     quad_b
);
  localparam int PHASE_W = 2 * HALF_W;

  logic [PHASE_W-1:0] incr_a, incr_b;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic               sel;
    logic [HALF_W-1:0]  lo_hold;
    logic [PHASE_W-1:0] step;
    logic [PHASE_W-1:0] acc;

    assign sel = wr_en && (wr_chan == 1'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_hold <= '0;
        step    <= '0;
        acc     <= '0;
      end else begin
        if (sel && !wr_hi) lo_hold <= wr_data;
        if (sel && wr_hi)  step    <= {wr_data, lo_hold};
        if (smp_en)        acc     <= acc + step;
      end
    end
  end

  assign phase_a = g_ch[0].acc;
  assign phase_b = g_ch[1].acc;
  assign incr_a  = g_ch[0].step;
  assign incr_b  = g_ch[1].step;
  assign quad_a  = phase_a[PHASE_W-1 -: QUAD_W];
  assign quad_b  = phase_b[PHASE_W-1 -: QUAD_W];
endmodule

// File: rtl/dual_nco_phase_chk.sv
module dual_nco_phase_chk #(
  parameter int HALF_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                wr_chan,
  input logic                wr_hi,
  input logic [HALF_W-1:0]   wr_data,
  input logic                smp_en,
  input logic [2*HALF_W-1:0] phase_a,
  input logic [2*HALF_W-1:0] phase_b,
  input logic [2*HALF_W-1:0] incr_a,
  input logic [2*HALF_W-1:0] incr_b
);
  localparam int PHASE_W = 2 * HALF_W;

  AST_STEP_A: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> phase_a == PHASE_W'($past(phase_a) + $past(incr_a))); // R5
  AST_STEP_B: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> phase_b == PHASE_W'($past(phase_b) + $past(incr_b))); // R5
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(phase_a)); // R6
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(phase_b)); // R6
  AST_LO_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> ($stable(incr_a) && $stable(incr_b))); // R2
  AST_COMMIT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi && !wr_chan) |=> (incr_a[PHASE_W-1:HALF_W] == $past(wr_data) && $stable(incr_b))); // R3 R4
  AST_COMMIT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi && wr_chan) |=> (incr_b[PHASE_W-1:HALF_W] == $past(wr_data) && $stable(incr_a))); // R3 R4
endmodule

bind dual_nco_phase dual_nco_phase_chk #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/dual_nco_phase_tb.sv
module dual_nco_phase_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0, wr_chan = 0, wr_hi = 0, smp_en = 0;
  logic [11:0] wr_data = '0;
  logic [23:0] phase_a, phase_b;
  logic [1:0]  quad_a, quad_b;

  int checks = 0, errors = 0;
  logic [23:0] m_phase [2];
  logic [23:0] m_step  [2];
  logic [11:0] m_lo    [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_nco_phase u_dut (.*);

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_both(string req);
    chk(req, phase_a, m_phase[0]);
    chk(req, phase_b, m_phase[1]);
  endtask

  task automatic cyc(bit we, bit ch, bit hi, logic [11:0] d, bit se);
    @(negedge clk);
    wr_en = we; wr_chan = ch; wr_hi = hi; wr_data = d; smp_en = se;
    @(posedge clk);
    if (se) for (int c = 0; c < 2; c++) m_phase[c] = m_phase[c] + m_step[c];
    if (we && !hi) m_lo[ch] = d;
    if (we && hi)  m_step[ch] = {d, m_lo[ch]};
    @(negedge clk);
    wr_en = 0; smp_en = 0;
  endtask

  task automatic set_step(bit ch, logic [23:0] s);
    cyc(1, ch, 0, s[11:0], 0);
    cyc(1, ch, 1, s[23:12], 0);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 1);
  endtask

  task automatic do_reset;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < 2; c++) begin m_phase[c] = 0; m_step[c] = 0; m_lo[c] = 0; end
  endtask

  task automatic t_reset;
    do_reset();
    chk_both("R1 reset phase");
    chk("R1 reset quad", {20'd0, quad_b, quad_a}, 24'd0);
    steps(3);
    chk_both("R1 zero step after reset");
  endtask

  task automatic t_low_only;
    do_reset();
    set_step(0, 24'h000100);
    cyc(1, 0, 0, 12'hABC, 0);
    steps(2);
    chk_both("R2 low half does not change step");
  endtask

  task automatic t_commit;
    do_reset();
    set_step(0, 24'h000010);
    cyc(1, 0, 0, 12'h000, 0);
    cyc(1, 0, 1, 12'h001, 1);
    chk("R3 same-edge uses old step", phase_a, 24'h000010);
    steps(1);
    chk("R3 new step active next edge", phase_a, 24'h001010);
    chk_both("R3 model");
  endtask

  task automatic t_independent;
    do_reset();
    set_step(1, 24'h123456);
    steps(2);
    chk("R4 channel A untouched", phase_a, 24'h0);
    set_step(0, 24'h000001);
    steps(3);
    chk_both("R4 independent channels");
  endtask

  task automatic t_wrap;
    do_reset();
    set_step(0, 24'hFFFFFF);
    steps(1);
    chk("R5 first step", phase_a, 24'hFFFFFF);
    steps(1);
    chk("R5 wrap modulo 2^24", phase_a, 24'hFFFFFE);
  endtask

  task automatic t_hold;
    do_reset();
    set_step(0, 24'h000333);
    set_step(1, 24'h000777);
    steps(2);
    repeat (4) cyc(0, 0, 0, '0, 0);
    chk_both("R6 hold without enable");
  endtask

  task automatic t_quadrant;
    do_reset();
    set_step(1, 24'h400000);
    for (int q = 1; q <= 4; q++) begin
      steps(1);
      chk("R7 quadrant", {22'd0, quad_b}, 24'(q % 4));
    end
  endtask

  task automatic t_reuse_low;
    do_reset();
    set_step(0, 24'h001055);
    cyc(1, 0, 1, 12'h002, 0);
    steps(1);
    chk("R8 reuse held low half", phase_a, 24'h002055);
  endtask

  task automatic t_if_word;
    logic [63:0] w;
    w = (64'd10700 << 24) / 64'd18432;
    chk("R9 truncated step", w[23:0], 24'h949C71);
    do_reset();
    set_step(0, w[23:0]);
    set_step(1, w[23:0]);
    steps(100);
    chk_both("R9 accumulate 10.7 MHz word");
    chk("R9 phase after 100 samples", phase_a, 24'((w * 100) & 64'hFFFFFF));
  endtask

  initial begin
    t_reset();
    t_low_only();
    t_commit();
    t_independent();
    t_wrap();
    t_hold();
    t_quadrant();
    t_reuse_low();
    t_if_word();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule